// File: doc/BRIEF.md
# SATA Host Port Interrupt Status Register Bank

This block holds the 32-bit interrupt status word for each port of a SATA host controller that follows the AHCI register model. Up to eight ports sit behind one simple register bus, and a port is picked by its address offset. Hardware event pulses from the link, transport and DMA logic set sticky status bits. Software clears those bits by writing ones to them.

Two bits do not store anything. They are live copies of the PhyRdy-change and connect-change diagnostic flags held in each port's error register. That register lives outside this block and arrives here as input signals. The device-interlock bit is gated by a platform capability strap.

Each port drives an interrupt request. It is high when any visible status bit is also set in that port's enable mask.

Top module: `port_intr_status`

## Requirements
- R1: After reset every stored status bit of every port is 0, so with the diagnostic inputs low every port reads 00000000h and every interrupt request is low.
- R2: Port p answers at byte address BASE_ADDR + p*80h (default 110h, 190h, 210h, 290h, 310h, 390h). Any other address reads 0, and a write to it changes no port.
- R3: An event pulse on a port sets the matching bit: host fatal 29, host data error 28, link fatal 27, link non-fatal 26, overrun 24, port-multiplier mismatch 23, interlock 7. The bit is visible on the cycle after the pulse and stays set until it is cleared.
- R4: Bit 30 sets only when a task-file status update and that status's error bit are both high in the same cycle.
- R5: Bit 5 sets only when a descriptor completion arrives together with that descriptor's interrupt flag.
- R6: Writing 1 to a bit among 30, 29, 28, 27, 26, 24, 23, 7 and 5 clears it from the next cycle on. Writing 0 to a bit leaves it unchanged.
- R7: If a set event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R8: Bit 22 always equals the port's PhyRdy-change diagnostic input, and bit 6 always equals its connect-change input. Writes to these bits have no effect.
- R9: Bit 31, bit 25, bits 21:8 and bits 4:0 always read 0.
- R10: While the mechanical-switch capability strap is low, bit 7 reads 0 and interlock events are not recorded.
- R11: A port's interrupt request is the OR of its 32 visible status bits ANDed with that port's 32-bit enable mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Register byte address |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data; ones clear status bits |
| busRdData | output | 32 | Status word of the addressed port, 0 if no port matches |
| evtTfUpdate | input | NUM_PORTS | Device updated the task-file status |
| evtTfErr | input | NUM_PORTS | Error bit of that task-file status |
| evtHostFatal | input | NUM_PORTS | Unrecoverable host bus error |
| evtHostData | input | NUM_PORTS | Host memory data error |
| evtLinkFatal | input | NUM_PORTS | Link error that stopped the transfer |
| evtLinkNonFatal | input | NUM_PORTS | Link error the transfer survived |
| evtOverrun | input | NUM_PORTS | Device sent more bytes than the descriptors allowed |
| evtPmMismatch | input | NUM_PORTS | Frame carried an unexpected port-multiplier field |
| evtInterlock | input | NUM_PORTS | Mechanical presence switch changed |
| evtDescDone | input | NUM_PORTS | A descriptor finished its data |
| evtDescIrqFlag | input | NUM_PORTS | Finished descriptor had its interrupt flag set |
| diagPhyChg | input | NUM_PORTS | PhyRdy-change flag of the port error register |
| diagConnChg | input | NUM_PORTS | Connect-change flag of the port error register |
| capMechSwitch | input | 1 | Platform has a mechanical presence switch |
| intEnable | input | 32*NUM_PORTS | Per-port enable mask; port p uses bits 32p+31:32p |
| intReq | output | NUM_PORTS | Per-port interrupt request |

## Verification
The checker watches these rules on every cycle, for every port:
- reserved bits stay zero on the read bus;
- the two mirrored bits track the error-register inputs;
- the interlock bit is held at zero while the strap is low;
- the interrupt request matches status ANDed with the enable mask;
- an overrun pulse is always visible on the next cycle;
- a clean write-one-to-clear takes the bit down.

Other behaviour needs the bench's scenarios:
- address aliasing and misaligned or out-of-range offsets;
- the two-input conditions on bits 30 and 5;
- the set-over-clear collision;
- a bit staying set across writes of zero;
- the strap dropping and returning while an interlock bit is held.

// File: rtl/port_intr_status_pkg.sv
package port_intr_status_pkg;
  localparam int MAX_PORTS  = 8;
  localparam int PORT_IDX_W = $clog2(MAX_PORTS);

  localparam int BIT_TFE  = 30;
  localparam int BIT_HBF  = 29;
  localparam int BIT_HBD  = 28;
  localparam int BIT_LKF  = 27;
  localparam int BIT_LKN  = 26;
  localparam int BIT_OVR  = 24;
  localparam int BIT_PMM  = 23;
  localparam int BIT_PHY  = 22;
  localparam int BIT_ILK  = 7;
  localparam int BIT_CONN = 6;
  localparam int BIT_DPS  = 5;

  // Sticky write-one-to-clear bits
  localparam logic [31:0] W1C_MASK = (32'd1 << BIT_TFE) | (32'd1 << BIT_HBF) |
                                     (32'd1 << BIT_HBD) | (32'd1 << BIT_LKF) |
                                     (32'd1 << BIT_LKN) | (32'd1 << BIT_OVR) |
                                     (32'd1 << BIT_PMM) | (32'd1 << BIT_ILK) |
                                     (32'd1 << BIT_DPS);
  localparam logic [31:0] MIRROR_MASK = (32'd1 << BIT_PHY) | (32'd1 << BIT_CONN);
  localparam logic [31:0] ZERO_MASK   = ~(W1C_MASK | MIRROR_MASK);

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic                  hit;
    logic                  wrStb;
    logic [PORT_IDX_W-1:0] portSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/port_intr_status_ctrl.sv
module port_intr_status_ctrl
  import port_intr_status_pkg::*;
#(
  parameter int              NUM_PORTS  = 6,
  parameter int              ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 12'h110,
  parameter int              STRIDE_LOG = 7
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctrlStrobe_t       strobe
);
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] slot;
  logic              inRange;
  logic              aligned;
  logic              slotOk;

  always_comb begin
    offs    = busAddr - BASE_ADDR;
    slot    = offs >> STRIDE_LOG;
    inRange = (busAddr >= BASE_ADDR);
    aligned = (offs[STRIDE_LOG-1:0] == '0);
    slotOk  = (slot < ADDR_W'(NUM_PORTS));
    strobe.hit     = inRange && aligned && slotOk;
    strobe.wrStb   = strobe.hit && busWrEn;
    strobe.portSel = slot[PORT_IDX_W-1:0];
  end
endmodule

// File: rtl/port_intr_status_dp.sv
module port_intr_status_dp
  import port_intr_status_pkg::*;
#(
  parameter int NUM_PORTS = 6
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [31:0]              wrData,
  input  logic [NUM_PORTS-1:0]     evtTfUpdate,
  input  logic [NUM_PORTS-1:0]     evtTfErr,
  input  logic [NUM_PORTS-1:0]     evtHostFatal,
  input  logic [NUM_PORTS-1:0]     evtHostData,
  input  logic [NUM_PORTS-1:0]     evtLinkFatal,
  input  logic [NUM_PORTS-1:0]     evtLinkNonFatal,
  input  logic [NUM_PORTS-1:0]     evtOverrun,
  input  logic [NUM_PORTS-1:0]     evtPmMismatch,
  input  logic [NUM_PORTS-1:0]     evtInterlock,
  input  logic [NUM_PORTS-1:0]     evtDescDone,
  input  logic [NUM_PORTS-1:0]     evtDescIrqFlag,
  input  logic [NUM_PORTS-1:0]     diagPhyChg,
  input  logic [NUM_PORTS-1:0]     diagConnChg,
  input  logic                     capMechSwitch,
  input  logic [32*NUM_PORTS-1:0]  intEnable,
  output logic [32*NUM_PORTS-1:0]  statusView,
  output logic [31:0]              rdData,
  output logic [NUM_PORTS-1:0]     intReq
);
  logic [31:0] views [NUM_PORTS];
  logic [31:0] capMask;

  assign capMask = capMechSwitch ? 32'hFFFF_FFFF : ~(32'd1 << BIT_ILK);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [31:0] sticky;
    logic [31:0] setVec;
    logic [31:0] clrVec;

    always_comb begin
      setVec          = '0;
      setVec[BIT_TFE] = evtTfUpdate[p] & evtTfErr[p];
      setVec[BIT_HBF] = evtHostFatal[p];
      setVec[BIT_HBD] = evtHostData[p];
      setVec[BIT_LKF] = evtLinkFatal[p];
      setVec[BIT_LKN] = evtLinkNonFatal[p];
      setVec[BIT_OVR] = evtOverrun[p];
      setVec[BIT_PMM] = evtPmMismatch[p];
      setVec[BIT_ILK] = evtInterlock[p] & capMechSwitch;
      setVec[BIT_DPS] = evtDescDone[p] & evtDescIrqFlag[p];
    end

    always_comb begin
      if (strobe.wrStb && (strobe.portSel == PORT_IDX_W'(p)))
        clrVec = wrData & W1C_MASK;
      else
        clrVec = '0;
    end

    // Set has priority: it is ORed in after the clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sticky <= '0;
      else       sticky <= (sticky & ~clrVec) | setVec;
    end

    always_comb begin
      views[p] = (sticky & W1C_MASK & capMask)
               | (32'(diagPhyChg[p])  << BIT_PHY)
               | (32'(diagConnChg[p]) << BIT_CONN);
    end

    assign statusView[32*p +: 32] = views[p];
    assign intReq[p] = |(views[p] & intEnable[32*p +: 32]);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (strobe.hit && (strobe.portSel == PORT_IDX_W'(i)))
        rdData = views[i];
  end
endmodule

// File: rtl/port_intr_status.sv
module port_intr_status
  import port_intr_status_pkg::*;
#(
  parameter int                NUM_PORTS  = 6,
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 12'h110,
  parameter int                STRIDE_LOG = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [31:0]             busWrData,
  output logic [31:0]             busRdData,
  input  logic [NUM_PORTS-1:0]    evtTfUpdate,
  input  logic [NUM_PORTS-1:0]    evtTfErr,
  input  logic [NUM_PORTS-1:0]    evtHostFatal,
  input  logic [NUM_PORTS-1:0]    evtHostData,
  input  logic [NUM_PORTS-1:0]    evtLinkFatal,
  input  logic [NUM_PORTS-1:0]    evtLinkNonFatal,
  input  logic [NUM_PORTS-1:0]    evtOverrun,
  input  logic [NUM_PORTS-1:0]    evtPmMismatch,
  input  logic [NUM_PORTS-1:0]    evtInterlock,
  input  logic [NUM_PORTS-1:0]    evtDescDone,
  input  logic [NUM_PORTS-1:0]    evtDescIrqFlag,
  input  logic [NUM_PORTS-1:0]    diagPhyChg,
  input  logic [NUM_PORTS-1:0]    diagConnChg,
  input  logic                    capMechSwitch,
  input  logic [32*NUM_PORTS-1:0] intEnable,
  output logic [NUM_PORTS-1:0]    intReq
);
  ctrlStrobe_t             strobe;
  logic [32*NUM_PORTS-1:0] statusView;

  port_intr_status_ctrl #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W),
    .BASE_ADDR(BASE_ADDR), .STRIDE_LOG(STRIDE_LOG)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .strobe(strobe)
  );

  port_intr_status_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .evtTfUpdate(evtTfUpdate), .evtTfErr(evtTfErr),
    .evtHostFatal(evtHostFatal), .evtHostData(evtHostData),
    .evtLinkFatal(evtLinkFatal), .evtLinkNonFatal(evtLinkNonFatal),
    .evtOverrun(evtOverrun), .evtPmMismatch(evtPmMismatch),
    .evtInterlock(evtInterlock), .evtDescDone(evtDescDone),
    .evtDescIrqFlag(evtDescIrqFlag), .diagPhyChg(diagPhyChg),
    .diagConnChg(diagConnChg), .capMechSwitch(capMechSwitch),
    .intEnable(intEnable), .statusView(statusView),
    .rdData(busRdData), .intReq(intReq)
  );
endmodule

// File: rtl/port_intr_status_chk.sv
module port_intr_status_chk
  import port_intr_status_pkg::*;
#(
  parameter int                NUM_PORTS  = 6,
  parameter int                ADDR_W     = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 12'h110,
  parameter int                STRIDE_LOG = 7
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [ADDR_W-1:0]       busAddr,
  input logic                    busWrEn,
  input logic [31:0]             busWrData,
  input logic [31:0]             busRdData,
  input logic [NUM_PORTS-1:0]    evtOverrun,
  input logic [NUM_PORTS-1:0]    diagPhyChg,
  input logic [NUM_PORTS-1:0]    diagConnChg,
  input logic                    capMechSwitch,
  input logic [32*NUM_PORTS-1:0] intEnable,
  input logic [32*NUM_PORTS-1:0] statusView,
  input logic [NUM_PORTS-1:0]    intReq
);
  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData & ZERO_MASK) == 32'd0);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    localparam logic [ADDR_W-1:0] PORT_ADDR = BASE_ADDR + ADDR_W'(p << STRIDE_LOG);

    // R8
    mirror_track_chk: assert property (@(posedge clk) disable iff (!rstN)
      (statusView[32*p + BIT_PHY] == diagPhyChg[p]) &&
      (statusView[32*p + BIT_CONN] == diagConnChg[p]));

    // R10
    cap_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      !capMechSwitch |-> !statusView[32*p + BIT_ILK]);

    // R11
    irq_combine_chk: assert property (@(posedge clk) disable iff (!rstN)
      intReq[p] == (|(statusView[32*p +: 32] & intEnable[32*p +: 32])));

    // R3
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      evtOverrun[p] |=> statusView[32*p + BIT_OVR]);

    // R6
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && busAddr == PORT_ADDR && busWrData[BIT_OVR] && !evtOverrun[p])
        |=> !statusView[32*p + BIT_OVR]);
  end
endmodule

bind port_intr_status port_intr_status_chk #(
  .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W),
  .BASE_ADDR(BASE_ADDR), .STRIDE_LOG(STRIDE_LOG)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .evtOverrun(evtOverrun),
  .diagPhyChg(diagPhyChg), .diagConnChg(diagConnChg),
  .capMechSwitch(capMechSwitch), .intEnable(intEnable),
  .statusView(statusView), .intReq(intReq)
);

// File: tb/test_port_intr_status.sv
`timescale 1ns/1ps
module test_port_intr_status;
  localparam int NP = 6;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [11:0]     busAddr = '0;
  logic            busWrEn = 1'b0;
  logic [31:0]     busWrData = '0;
  logic [31:0]     busRdData;
  logic [NP-1:0]   evtTfUpdate = '0, evtTfErr = '0, evtHostFatal = '0, evtHostData = '0;
  logic [NP-1:0]   evtLinkFatal = '0, evtLinkNonFatal = '0, evtOverrun = '0;
  logic [NP-1:0]   evtPmMismatch = '0, evtInterlock = '0, evtDescDone = '0;
  logic [NP-1:0]   evtDescIrqFlag = '0, diagPhyChg = '0, diagConnChg = '0;
  logic            capMechSwitch = 1'b1;
  logic [32*NP-1:0] intEnable = '0;
  logic [NP-1:0]   intReq;

  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  port_intr_status i_port_intr_status (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .evtTfUpdate(evtTfUpdate), .evtTfErr(evtTfErr),
    .evtHostFatal(evtHostFatal), .evtHostData(evtHostData),
    .evtLinkFatal(evtLinkFatal), .evtLinkNonFatal(evtLinkNonFatal),
    .evtOverrun(evtOverrun), .evtPmMismatch(evtPmMismatch),
    .evtInterlock(evtInterlock), .evtDescDone(evtDescDone),
    .evtDescIrqFlag(evtDescIrqFlag), .diagPhyChg(diagPhyChg),
    .diagConnChg(diagConnChg), .capMechSwitch(capMechSwitch),
    .intEnable(intEnable), .intReq(intReq)
  );

  // evt codes: 0 task-file error (update+err), 1 host fatal, 2 host data,
  // 3 link fatal, 4 link non-fatal, 5 overrun, 6 pm mismatch, 7 interlock,
  // 8 descriptor done with irq flag, 15 none
  typedef struct packed {
    logic [2:0]  port;
    logic [3:0]  evt;
    logic [31:0] clr;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 4'd5,  32'h0000_0000, 32'h0100_0000},
    '{3'd0, 4'd1,  32'h0000_0000, 32'h2100_0000},
    '{3'd0, 4'd15, 32'h0100_0000, 32'h2000_0000},
    '{3'd0, 4'd15, 32'h0000_0000, 32'h2000_0000},
    '{3'd0, 4'd15, 32'hFFFF_FFFF, 32'h0000_0000},
    '{3'd3, 4'd8,  32'h0000_0000, 32'h0000_0020},
    '{3'd3, 4'd7,  32'h0000_0000, 32'h0000_00A0},
    '{3'd5, 4'd0,  32'h0000_0000, 32'h4000_0000},
    '{3'd5, 4'd2,  32'h4000_0000, 32'h1000_0000},
    '{3'd1, 4'd3,  32'h0000_0000, 32'h0800_0000},
    '{3'd1, 4'd4,  32'h0000_0000, 32'h0C00_0000},
    '{3'd1, 4'd6,  32'h0800_0000, 32'h0480_0000},
    '{3'd3, 4'd15, 32'h0000_0080, 32'h0000_0020}
  };

  function automatic logic [11:0] portAddr(input int p);
    return 12'h110 + 12'(p * 12'h080);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic setEvt(input int p, input int code, input logic v);
    case (code)
      0: begin evtTfUpdate[p] = v; evtTfErr[p] = v; end
      1: evtHostFatal[p] = v;
      2: evtHostData[p] = v;
      3: evtLinkFatal[p] = v;
      4: evtLinkNonFatal[p] = v;
      5: evtOverrun[p] = v;
      6: evtPmMismatch[p] = v;
      7: evtInterlock[p] = v;
      8: begin evtDescDone[p] = v; evtDescIrqFlag[p] = v; end
      default: ;
    endcase
  endtask

  task automatic pulseEvt(input int p, input int code);
    @(negedge clk); setEvt(p, code, 1'b1);
    @(negedge clk); setEvt(p, code, 1'b0);
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1; d = busRdData;
  endtask

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int p = 0; p < NP; p++) begin
      busRead(portAddr(p), rd);
      check("R1 reset read", rd, 32'h0);
    end
    check("R1 reset intReq", 32'(intReq), 32'h0);

    // Vector table: R3 R4 R5 R6 R10
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].evt != 4'd15) pulseEvt(int'(VECS[i].port), int'(VECS[i].evt));
      busWrite(portAddr(int'(VECS[i].port)), VECS[i].clr);
      busRead(portAddr(int'(VECS[i].port)), rd);
      check("R3/R6 vector", rd, VECS[i].exp);
    end

    // R11: port1 holds 04800000h
    @(negedge clk); intEnable[32 +: 32] = 32'h0080_0000; #1;
    check("R11 enabled bit raises irq", 32'(intReq), 32'h2);
    @(negedge clk); intEnable[32 +: 32] = 32'h0000_0001; #1;
    check("R11 masked bit no irq", 32'(intReq), 32'h0);
    @(negedge clk); intEnable = '0;
    busWrite(portAddr(1), 32'hFFFF_FFFF);
    busWrite(portAddr(3), 32'hFFFF_FFFF);
    busWrite(portAddr(5), 32'hFFFF_FFFF);

    // R4: one half of the task-file condition alone
    @(negedge clk); evtTfUpdate[2] = 1'b1;
    @(negedge clk); evtTfUpdate[2] = 1'b0; evtTfErr[2] = 1'b1;
    @(negedge clk); evtTfErr[2] = 1'b0;
    busRead(portAddr(2), rd);
    check("R4 bit30 needs update and err", rd, 32'h0);

    // R5: completion without irq flag, flag without completion
    @(negedge clk); evtDescDone[2] = 1'b1;
    @(negedge clk); evtDescDone[2] = 1'b0; evtDescIrqFlag[2] = 1'b1;
    @(negedge clk); evtDescIrqFlag[2] = 1'b0;
    busRead(portAddr(2), rd);
    check("R5 bit5 needs done and flag", rd, 32'h0);

    // R7: set and clear in one cycle
    @(negedge clk);
    evtOverrun[4] = 1'b1; busAddr = portAddr(4); busWrData = 32'h0100_0000; busWrEn = 1'b1;
    @(negedge clk);
    evtOverrun[4] = 1'b0; busWrEn = 1'b0;
    busRead(portAddr(4), rd);
    check("R7 set wins over clear", rd, 32'h0100_0000);
    busWrite(portAddr(4), 32'h0100_0000);
    busRead(portAddr(4), rd);
    check("R6 clear after collision", rd, 32'h0);

    // R10: strap low blocks and hides bit 7
    @(negedge clk); capMechSwitch = 1'b0;
    pulseEvt(2, 7);
    busRead(portAddr(2), rd);
    check("R10 interlock ignored with strap low", rd, 32'h0);
    @(negedge clk); capMechSwitch = 1'b1;
    busRead(portAddr(2), rd);
    check("R10 interlock not recorded", rd, 32'h0);
    pulseEvt(2, 7);
    busRead(portAddr(2), rd);
    check("R10 interlock set with strap", rd, 32'h0000_0080);
    @(negedge clk); capMechSwitch = 1'b0;
    busRead(portAddr(2), rd);
    check("R10 bit7 hidden with strap low", rd, 32'h0);
    @(negedge clk); capMechSwitch = 1'b1;
    busWrite(portAddr(2), 32'h0000_0080);

    // R8: mirrored bits
    @(negedge clk); diagPhyChg[2] = 1'b1; diagConnChg[2] = 1'b1;
    busRead(portAddr(2), rd);
    check("R8 mirrors follow inputs", rd, 32'h0040_0040);
    busWrite(portAddr(2), 32'h0040_0040);
    busRead(portAddr(2), rd);
    check("R8 write has no effect on mirrors", rd, 32'h0040_0040);
    @(negedge clk); diagPhyChg[2] = 1'b0;
    busRead(portAddr(2), rd);
    check("R8 phy mirror drops", rd, 32'h0000_0040);
    @(negedge clk); diagConnChg[2] = 1'b0;
    busRead(portAddr(2), rd);
    check("R8 conn mirror drops", rd, 32'h0);

    // R2: address decode
    pulseEvt(0, 5);
    busWrite(12'h118, 32'hFFFF_FFFF);
    busWrite(12'h410, 32'hFFFF_FFFF);
    busRead(portAddr(0), rd);
    check("R2 stray writes ignored", rd, 32'h0100_0000);
    busRead(12'h118, rd);
    check("R2 misaligned reads zero", rd, 32'h0);
    busRead(12'h410, rd);
    check("R2 beyond last port reads zero", rd, 32'h0);
    busRead(12'h090, rd);
    check("R2 below base reads zero", rd, 32'h0);
    busRead(portAddr(1), rd);
    check("R2 other port untouched", rd, 32'h0);
    busWrite(portAddr(0), 32'hFFFF_FFFF);

    // R9: every event at once, only defined bits appear
    @(negedge clk);
    for (int c = 0; c < 9; c++) setEvt(0, c, 1'b1);
    @(negedge clk);
    for (int c = 0; c < 9; c++) setEvt(0, c, 1'b0);
    busRead(portAddr(0), rd);
    check("R9 reserved bits read zero", rd, 32'h7D80_00A0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule